// File: doc/BRIEF.md
# Serial Audio DAC Word Transmitter

This block takes signed 20-bit audio samples, one at a time, over a valid/ready handshake. It sends each sample to the input shift register of a serial audio DAC over three wires: a data line, a generated bit clock and an active-low latch enable. The bits go out most significant first. The DAC samples the data line on each rising edge of the bit clock. After exactly twenty rising edges the block drops the latch line for a fixed number of system clocks, and that pulse moves the twenty newest bits into the converter.

All bit-clock and latch timing is counted in system clocks. `HALF_DIV` sets the length of each bit-clock phase. `LATCH_W` sets the latch pulse width and also the quiet gaps before and after the pulse. The user picks these two values so that every edge meets the converter's minimum widths and its setup and hold windows. Elaboration checks reject settings that break those minimums for the given system clock period. The word rate then follows from the divider, so one design covers 2x to 16x oversampled streams. Before the pulse, the bit clock stays low and the data line holds the last bit. Between words the bit clock and the data line are both low.

Top module: `dac_word_tx`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the outputs are in the idle state: `dac_clk` low, `dac_le_n` high, `dac_data` low and `s_ready` high.
- R2: Each accepted sample produces exactly WORD_W (20) rising edges of `dac_clk` before the latch pulse. The value on `dac_data` at those edges, taken in order, is the sample with the most significant bit first. This covers full-scale negative (0x80000), full-scale positive (0x7FFFF), all-ones and mixed patterns.
- R3: `dac_data` changes only while `dac_clk` is low. It is stable across every rising edge and for the whole high phase.
- R4: Within a word, every high phase of `dac_clk` lasts exactly HALF_DIV system clocks. Every low phase between two rising edges also lasts exactly HALF_DIV system clocks.
- R5: `dac_le_n` falls exactly LATCH_W system clocks after the last falling edge of `dac_clk` and stays low for exactly LATCH_W system clocks. `dac_clk` is low throughout the pulse.
- R6: `s_ready` falls on the cycle after a sample is accepted. It stays low through shifting, the latch pulse and the gap after it, and it is low whenever `dac_le_n` is low.
- R7: A sample is accepted only when `s_valid` and `s_ready` are both high. Changes on `s_data` or `s_valid` while a word is in flight do not alter the transmitted word and do not add an extra word.
- R8: When `s_valid` is held high, words follow each other back to back. Successive latch pulses are 40*HALF_DIV + 3*LATCH_W + 1 system clocks apart.
- R9: A synchronous reset raised partway through a word returns the outputs to idle on the next cycle. The aborted word produces no latch pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Block can accept a sample |
| s_data | input | WORD_W | Signed sample, two's complement |
| dac_clk | output | 1 | Generated bit clock, idles low |
| dac_data | output | 1 | Serial data, MSB first |
| dac_le_n | output | 1 | Latch enable, active low |

## Verification
On every cycle the assertions check four things: data stability while the bit clock is high, the clock staying low and the handshake closed during the latch pulse, the idle outputs after reset, and the rising-edge count at each latch. Only the directed scenarios can show the phase lengths, the latch gap and width, and the latched value matching the sample. The same holds for the spacing of back-to-back words and for the suppression of the latch after an aborted word.

// File: rtl/dac_word_tx_pkg.sv
package dac_word_tx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_GAP_PRE,
      ST_LATCH,
      ST_GAP_POST
   } tx_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/dac_tx_timer.sv
module dac_tx_timer #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clear,
   input  logic [CW-1:0] lim,
   output logic          done
);
   logic [CW-1:0] cnt;

   assign done = (cnt == lim - CW'(1));

   always_ff @(posedge clk) begin
      if (rst || clear || done) cnt <= '0;
      else                      cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/dac_tx_shifter.sv
module dac_tx_shifter #(
   parameter int WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              shift,
   input  logic [WORD_W-1:0] din,
   output logic              msb
);
   logic [WORD_W-1:0] sh;

   assign msb = sh[WORD_W-1];

   always_ff @(posedge clk) begin
      if (rst)        sh <= '0;
      else if (load)  sh <= din;
      else if (shift) sh <= {sh[WORD_W-2:0], 1'b0};
   end
endmodule

// File: rtl/dac_tx_seq.sv
module dac_tx_seq
   import dac_word_tx_pkg::*;
#(
   parameter int WORD_W   = 20,
   parameter int HALF_DIV = 2,
   parameter int LATCH_W  = 2,
   parameter int CW       = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          s_valid,
   input  logic          done,
   input  logic          sh_msb,
   output logic [CW-1:0] lim,
   output logic          t_clear,
   output logic          load,
   output logic          shift,
   output logic          s_ready,
   output logic          dac_clk,
   output logic          dac_data,
   output logic          dac_le_n
);
   localparam int BW = $clog2(WORD_W + 1);

   tx_state_t     state;
   logic [BW-1:0] bitn;
   logic          clk_q;
   logic          le_q;

   assign s_ready  = (state == ST_IDLE);
   assign load     = s_ready && s_valid;
   assign t_clear  = load;
   assign lim      = (state == ST_SHIFT) ? CW'(HALF_DIV) : CW'(LATCH_W);
   assign shift    = (state == ST_SHIFT) && done && clk_q && (bitn != BW'(WORD_W));
   assign dac_clk  = clk_q;
   assign dac_le_n = le_q;
   assign dac_data = (state != ST_IDLE) && sh_msb;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         bitn  <= '0;
         clk_q <= 1'b0;
         le_q  <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (s_valid) begin
                  state <= ST_SHIFT;
                  bitn  <= '0;
                  clk_q <= 1'b0;
               end
            end
            ST_SHIFT: begin
               if (done) begin
                  if (!clk_q) begin
                     clk_q <= 1'b1;
                     bitn  <= bitn + BW'(1);
                  end else begin
                     clk_q <= 1'b0;
                     if (bitn == BW'(WORD_W)) state <= ST_GAP_PRE;
                  end
               end
            end
            ST_GAP_PRE: begin
               if (done) begin
                  le_q  <= 1'b0;
                  state <= ST_LATCH;
               end
            end
            ST_LATCH: begin
               if (done) begin
                  le_q  <= 1'b1;
                  state <= ST_GAP_POST;
               end
            end
            ST_GAP_POST: begin
               if (done) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dac_word_tx.sv
module dac_word_tx
   import dac_word_tx_pkg::*;
#(
   parameter int WORD_W     = 20,
   parameter int HALF_DIV   = 2,
   parameter int LATCH_W    = 2,
   parameter int SYS_CLK_NS = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [WORD_W-1:0] s_data,
   output logic              dac_clk,
   output logic              dac_data,
   output logic              dac_le_n
);
   localparam int CW = $clog2(max2(HALF_DIV, LATCH_W) + 1);

   if (WORD_W < 2) begin : g_bad_width
      $error("WORD_W must be at least 2");
   end
   if (HALF_DIV < 1 || HALF_DIV * SYS_CLK_NS < 30) begin : g_bad_half
      $error("HALF_DIV too small for bit-clock phase and period minimums");
   end
   if (LATCH_W < 1 || LATCH_W * SYS_CLK_NS < 40) begin : g_bad_latch
      $error("LATCH_W too small for latch width and spacing minimums");
   end

   logic [CW-1:0] lim;
   logic          done;
   logic          t_clear;
   logic          load;
   logic          shift;
   logic          sh_msb;

   dac_tx_timer #(.CW(CW)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .clear (t_clear),
      .lim   (lim),
      .done  (done)
   );

   dac_tx_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .shift (shift),
      .din   (s_data),
      .msb   (sh_msb)
   );

   dac_tx_seq #(
      .WORD_W   (WORD_W),
      .HALF_DIV (HALF_DIV),
      .LATCH_W  (LATCH_W),
      .CW       (CW)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .s_valid  (s_valid),
      .done     (done),
      .sh_msb   (sh_msb),
      .lim      (lim),
      .t_clear  (t_clear),
      .load     (load),
      .shift    (shift),
      .s_ready  (s_ready),
      .dac_clk  (dac_clk),
      .dac_data (dac_data),
      .dac_le_n (dac_le_n)
   );
endmodule

// File: rtl/dac_word_tx_chk.sv
module dac_word_tx_chk #(
   parameter int WORD_W = 20
) (
   input logic clk,
   input logic rst,
   input logic s_valid,
   input logic s_ready,
   input logic dac_clk,
   input logic dac_data,
   input logic dac_le_n
);
   localparam int RW = $clog2(WORD_W + 1) + 1;

   logic [RW-1:0] rise_cnt;
   logic          prev_clk;

   always_ff @(posedge clk) begin
      if (rst) begin
         rise_cnt <= '0;
         prev_clk <= 1'b0;
      end else begin
         prev_clk <= dac_clk;
         if (s_valid && s_ready)     rise_cnt <= '0;
         else if (dac_clk && !prev_clk) rise_cnt <= rise_cnt + RW'(1);
      end
   end

   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (!dac_clk && dac_le_n && !dac_data && s_ready)); // R1

   AST_WORD_EDGES: assert property (@(posedge clk) disable iff (rst)
      $fell(dac_le_n) |-> (rise_cnt == RW'(WORD_W))); // R2

   AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
      dac_clk |-> $stable(dac_data)); // R3

   AST_CLK_LOW_LATCH: assert property (@(posedge clk) disable iff (rst)
      !dac_le_n |-> !dac_clk); // R5

   AST_BUSY_LATCH: assert property (@(posedge clk) disable iff (rst)
      !dac_le_n |-> !s_ready); // R6

   AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
      (s_valid && s_ready) |=> !s_ready); // R6
endmodule

bind dac_word_tx dac_word_tx_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .s_valid  (s_valid),
   .s_ready  (s_ready),
   .dac_clk  (dac_clk),
   .dac_data (dac_data),
   .dac_le_n (dac_le_n)
);

// File: tb/dac_word_tx_test.sv
module dac_word_tx_test;
   localparam int W = 20;
   localparam int H = 2;
   localparam int L = 2;
   localparam int PERIOD = 40 * H + 3 * L + 1;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         s_valid = 1'b0;
   logic         s_ready;
   logic [W-1:0] s_data = '0;
   logic         dac_clk;
   logic         dac_data;
   logic         dac_le_n;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   dac_word_tx #(.WORD_W(W), .HALF_DIV(H), .LATCH_W(L), .SYS_CLK_NS(20)) uut (
      .clk      (clk),
      .rst      (rst),
      .s_valid  (s_valid),
      .s_ready  (s_ready),
      .s_data   (s_data),
      .dac_clk  (dac_clk),
      .dac_data (dac_data),
      .dac_le_n (dac_le_n)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // receiver model, sampled between edges
   int           cyc = 0;
   int           rises = 0;
   logic [W-1:0] rx = '0;
   logic [W-1:0] latched = '0;
   int           nbits = 0;
   int           latch_cnt = 0;
   int           t_tr = 0;
   int           t_fall = 0;
   int           t_le = 0;
   int           t_le_prev = 0;
   logic         pclk = 1'b0;
   logic         ple = 1'b1;
   logic         pdata = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst) begin
         rises = 0;
         rx = '0;
      end else begin
         if (dac_clk && !pclk) begin
            check(dac_data == pdata, "R3 data across rising edge", dac_data, pdata);
            if (rises > 0) check(cyc - t_tr == H, "R4 low phase", cyc - t_tr, H);
            rx = {rx[W-2:0], dac_data};
            rises++;
            t_tr = cyc;
         end
         if (!dac_clk && pclk) begin
            check(cyc - t_tr == H, "R4 high phase", cyc - t_tr, H);
            t_tr = cyc;
            t_fall = cyc;
         end
         if (!dac_le_n && ple) begin
            check(cyc - t_fall == L, "R5 gap before latch", cyc - t_fall, L);
            check(!s_ready, "R6 ready low in latch", s_ready, 0);
            latched = rx;
            nbits = rises;
            t_le_prev = t_le;
            t_le = cyc;
            latch_cnt++;
         end
         if (dac_le_n && !ple) begin
            check(cyc - t_le == L, "R5 latch width", cyc - t_le, L);
            rises = 0;
         end
      end
      pclk = dac_clk;
      ple = dac_le_n;
      pdata = dac_data;
   end

   task automatic send(input logic [W-1:0] w);
      @(negedge clk);
      while (!s_ready) @(negedge clk);
      s_valid = 1'b1;
      s_data = w;
      @(negedge clk);
      s_valid = 1'b0;
      check(!s_ready, "R6 ready drops after accept", s_ready, 0);
   endtask

   task automatic wait_latch(input int n0);
      while (latch_cnt == n0) @(negedge clk);
      repeat (3 * L + 2) @(negedge clk);
   endtask

   task automatic t_reset_state();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(!dac_clk && dac_le_n && !dac_data && s_ready, "R1 outputs in reset",
            {dac_clk, dac_le_n, dac_data, s_ready}, 4'b0101);
      rst = 1'b0;
      @(negedge clk);
      check(!dac_clk && dac_le_n && !dac_data && s_ready, "R1 outputs after reset",
            {dac_clk, dac_le_n, dac_data, s_ready}, 4'b0101);
   endtask

   task automatic t_word(input logic [W-1:0] w);
      int n0 = latch_cnt;
      send(w);
      wait_latch(n0);
      check(latched == w, "R2 latched word", latched, w);
      check(nbits == W, "R2 rising edge count", nbits, W);
      check(!dac_clk && !dac_data && s_ready, "R1 idle after word",
            {dac_clk, dac_data, s_ready}, 3'b001);
   endtask

   task automatic t_busy_ignore();
      int n0 = latch_cnt;
      logic [W-1:0] w = 20'h3C5A9;
      send(w);
      repeat (10) @(negedge clk);
      s_valid = 1'b1;
      s_data = 20'h0F0F0;
      repeat (20) @(negedge clk);
      s_valid = 1'b0;
      s_data = 20'hFFFFF;
      wait_latch(n0);
      check(latched == w, "R7 word unchanged by busy inputs", latched, w);
      repeat (PERIOD) @(negedge clk);
      check(latch_cnt == n0 + 1, "R7 no extra word", latch_cnt, n0 + 1);
   endtask

   task automatic t_back_to_back();
      int n0 = latch_cnt;
      @(negedge clk);
      while (!s_ready) @(negedge clk);
      s_data = 20'h12345;
      s_valid = 1'b1;
      while (latch_cnt < n0 + 3) @(negedge clk);
      s_valid = 1'b0;
      check(t_le - t_le_prev == PERIOD, "R8 latch spacing", t_le - t_le_prev, PERIOD);
      check(latched == 20'h12345, "R8 streamed word", latched, 20'h12345);
      repeat (2 * PERIOD) @(negedge clk);
   endtask

   task automatic t_abort();
      int n0 = latch_cnt;
      @(negedge clk);
      while (!s_ready) @(negedge clk);
      s_valid = 1'b1;
      s_data = 20'hAAAAA;
      @(negedge clk);
      s_valid = 1'b0;
      repeat (25) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(!dac_clk && dac_le_n && !dac_data && s_ready, "R9 idle after mid-word reset",
            {dac_clk, dac_le_n, dac_data, s_ready}, 4'b0101);
      repeat (PERIOD + 10) @(negedge clk);
      check(latch_cnt == n0, "R9 aborted word not latched", latch_cnt, n0);
      t_word(20'h5F00D);
   endtask

   initial begin
      t_reset_state();
      t_word(20'h80000);
      t_word(20'h7FFFF);
      t_word(20'hFFFFF);
      t_word(20'h00001);
      t_word(20'hA5C3E);
      t_busy_ignore();
      t_back_to_back();
      t_abort();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule